// File: doc/BRIEF.md
# Strobe-Sequenced DRAM Cycle Decoder

This block is the control front end of an asynchronous, strobe-driven DRAM device that is emulated on a fast system clock. It watches the row strobe, the two byte-lane column strobes, the write strobe, the output enable and the multiplexed address pins. It does not decode a command word. It works out what kind of cycle is in progress from the order in which the strobes went low. It reports a cycle-type code, the row to open, the latched column, and per-lane read, write and drive enables. These go to the array, sense-amplifier and data-path logic, which sit outside the block.

When a refresh cycle supplies no row on the pins, the row comes from an internal refresh counter. The counter moves forward only on internal-address refreshes: column-before-row, hidden and self refresh. The row and column widths are parameters whose sum is fixed at 22 address bits. The same code therefore covers the 2k, 4k and 8k refresh geometries. A low-power build option adds a self-refresh mode, driven by a timer, that runs while the row strobe stays low.

All strobe inputs are registered once, and every output is registered. An output therefore shows a strobe change after two rising clock edges.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, cycle code is 0 (none), the active row and column are 0, and all lane enables are 0.
- R2: If the row strobe falls while both column strobes are high, the code becomes 4 (row-only refresh) and the active row is the row taken from the address pins. The refresh counter does not move.
- R3: A column strobe falling while a row is open latches the column from the address pins. The code becomes 1 (read) if the write strobe is high and 2 (write) if it is low. A later column strobe fall within the same row cycle latches a fresh column and decides the type again (page mode).
- R4: If the write strobe falls during a read, the code becomes 3 (read-modify-write), the column stays the same, and the lanes switch from read to write.
- R5: If the row strobe falls with any column strobe already low and the write strobe high, outside a held access, the code becomes 5 (column-before-row refresh). The active row is the refresh counter value, and the counter then steps by one, wrapping modulo 2^ROW_W.
- R6: If the row strobe falls with a column strobe low and the write strobe low, outside a held access, the code stays 0, no lane is enabled and the counter does not move.
- R7: Suppose a read or write ends with the row strobe rising while a column strobe stays low, and the row strobe then falls again. The code becomes 6 (hidden refresh), the active row is the counter value, the counter steps, and the column and lane enables of the access are kept.
- R8: With LOW_POWER set, holding the row strobe low for SREF_ENTRY cycles after a column-before-row refresh moves the code to 7 (self refresh). In this mode the active row follows the counter, which advances by exactly one every SREF_TICK cycles. Raising the row strobe ends the mode.
- R9: Lane 0 belongs to the lower column strobe and lane 1 to the upper. During a read, write or hidden refresh, the read enable of a lane is on when its column strobe is low and the write strobe is high. Its write enable is on when its column strobe and the write strobe are both low. The two are never on together.
- R10: A lane's drive enable is on only when its read enable is on and the output enable is low.
- R11: Once the row strobe is registered high, the code returns to 0 and every lane drive enable is off, including the gap between an access and a hidden refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_type | output | 3 | Cycle code (0 none, 1 read, 2 write, 3 RMW, 4 row-only, 5 CBR, 6 hidden, 7 self) |
| act_row | output | ROW_W | Row to activate |
| col_addr | output | COL_W | Latched column |
| rd_en | output | 2 | Per-lane read enable |
| wr_en | output | 2 | Per-lane write enable |
| lane_oe | output | 2 | Per-lane data drive enable |

## Verification
The embedded assertions check four things on every cycle. A registered-high row strobe always clears the cycle code. A lane never reads and writes at once. The refresh counter moves only when a step is requested. On entry to a column-before-row refresh the pre-increment counter value appears as the row, and both read-modify-write and hidden refresh keep the column. Which sequence of strobes leads to which code depends on whole scenarios, so only the bench shows it. The bench scenarios cover row-only versus page-mode access, the ignored write-low refresh, the counter wrapping over the full row range, hidden refresh after a held access, and the self-refresh tick rate.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  typedef enum logic [2:0] {
    CYC_NONE   = 3'd0,
    CYC_READ   = 3'd1,
    CYC_WRITE  = 3'd2,
    CYC_RMW    = 3'd3,
    CYC_ROR    = 3'd4,
    CYC_CBR    = 3'd5,
    CYC_HIDDEN = 3'd6,
    CYC_SELF   = 3'd7
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_CBR,
    ST_SELF,
    ST_HOLD,
    ST_HIDDEN,
    ST_SKIP
  } st_e;

  typedef struct packed {
    logic ras_n;
    logic lcas_n;
    logic ucas_n;
    logic we_n;
    logic oe_n;
  } strobes_s;

endpackage

// File: rtl/sdec_sampler.sv
module sdec_sampler
  import sdec_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_s          pins,
  input  logic [ADDR_W-1:0] addr_pins,
  output strobes_s          cur,
  output strobes_s          prev,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '1;
      prev   <= '1;
      addr_q <= '0;
    end else begin
      cur    <= pins;
      prev   <= cur;
      addr_q <= addr_pins;
    end
  end

endmodule

// File: rtl/sdec_refresh_counter.sv
module sdec_refresh_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt));

endmodule

// File: rtl/sdec_cycle_fsm.sv
module sdec_cycle_fsm
  import sdec_pkg::*;
#(
  parameter int ROW_W      = 13,
  parameter int COL_W      = 9,
  parameter int ADDR_W     = 13,
  parameter int LOW_POWER  = 1,
  parameter int SREF_ENTRY = 64,
  parameter int SREF_TICK  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_s          cur,
  input  strobes_s          prev,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [ROW_W-1:0]  cnt,
  output logic              step,
  output logic              acc_next,
  output cyc_e              cyc,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);

  localparam int ENT_W = $clog2(SREF_ENTRY + 1);
  localparam int TMR_W = $clog2(SREF_TICK + 1);

  st_e              st_q, st_d;
  cyc_e             cyc_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic [ENT_W-1:0] ent_q, ent_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  logic cas_low, cas_low_prev, ras_fall, cas_fall, we_fall, in_access;

  assign cas_low      = ~cur.lcas_n | ~cur.ucas_n;
  assign cas_low_prev = ~prev.lcas_n | ~prev.ucas_n;
  assign ras_fall     = prev.ras_n & ~cur.ras_n;
  assign cas_fall     = cas_low & ~cas_low_prev;
  assign we_fall      = prev.we_n & ~cur.we_n;
  assign in_access    = (cyc inside {CYC_READ, CYC_WRITE, CYC_RMW});

  always_comb begin
    st_d  = st_q;
    cyc_d = cyc;
    row_d = row;
    col_d = col;
    ent_d = ent_q;
    tmr_d = tmr_q;
    step  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ras_fall) begin
          if (cas_low) begin
            if (cur.we_n) begin
              st_d  = ST_CBR;
              cyc_d = CYC_CBR;
              row_d = cnt;
              step  = 1'b1;
              ent_d = '0;
            end else begin
              st_d  = ST_SKIP;
              cyc_d = CYC_NONE;
            end
          end else begin
            st_d  = ST_ROW;
            cyc_d = CYC_ROR;
            row_d = addr_q[ROW_W-1:0];
          end
        end
      end
      ST_ROW: begin
        if (cur.ras_n) begin
          st_d  = (cas_low && in_access) ? ST_HOLD : ST_IDLE;
          cyc_d = CYC_NONE;
        end else if (cas_fall) begin
          col_d = addr_q[COL_W-1:0];
          cyc_d = cur.we_n ? CYC_READ : CYC_WRITE;
        end else if (cyc == CYC_READ && we_fall) begin
          cyc_d = CYC_RMW;
        end
      end
      ST_HOLD: begin
        if (!cas_low) begin
          st_d = ST_IDLE;
        end else if (ras_fall) begin
          st_d  = ST_HIDDEN;
          cyc_d = CYC_HIDDEN;
          row_d = cnt;
          step  = 1'b1;
        end
      end
      ST_HIDDEN: begin
        if (cur.ras_n) begin
          st_d  = cas_low ? ST_HOLD : ST_IDLE;
          cyc_d = CYC_NONE;
        end
      end
      ST_CBR: begin
        if (cur.ras_n) begin
          st_d  = ST_IDLE;
          cyc_d = CYC_NONE;
        end else if (LOW_POWER != 0) begin
          if (ent_q == ENT_W'(SREF_ENTRY - 1)) begin
            st_d  = ST_SELF;
            cyc_d = CYC_SELF;
            tmr_d = '0;
          end else begin
            ent_d = ent_q + 1'b1;
          end
        end
      end
      ST_SELF: begin
        if (cur.ras_n) begin
          st_d  = ST_IDLE;
          cyc_d = CYC_NONE;
        end else begin
          row_d = cnt;
          if (tmr_q == TMR_W'(SREF_TICK - 1)) begin
            tmr_d = '0;
            step  = 1'b1;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
      end
      ST_SKIP: begin
        if (cur.ras_n) st_d = ST_IDLE;
      end
      default: begin
        st_d  = ST_IDLE;
        cyc_d = CYC_NONE;
      end
    endcase
  end

  assign acc_next = (st_d == ST_HIDDEN) ||
                    (st_d == ST_ROW && (cyc_d inside {CYC_READ, CYC_WRITE, CYC_RMW}));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cyc   <= CYC_NONE;
      row   <= '0;
      col   <= '0;
      ent_q <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      cyc   <= cyc_d;
      row   <= row_d;
      col   <= col_d;
      ent_q <= ent_d;
      tmr_q <= tmr_d;
    end
  end

  assert_ras_high_clears_R11: assert property (@(posedge clk) disable iff (rst)
    cur.ras_n |=> (cyc == CYC_NONE));

  assert_cbr_row_from_counter_R5: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CBR && $past(cyc) != CYC_CBR) |-> (row == $past(cnt)));

  assert_rmw_keeps_col_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_RMW && $past(cyc) == CYC_READ) |-> $stable(col));

  assert_hidden_keeps_col_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_HIDDEN && $past(cyc) != CYC_HIDDEN) |-> $stable(col));

endmodule

// File: rtl/sdec_lane_ctrl.sv
module sdec_lane_ctrl
  import sdec_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_s         cur,
  input  logic             acc_next,
  output logic [LANES-1:0] rd_en,
  output logic [LANES-1:0] wr_en,
  output logic [LANES-1:0] drv_en
);

  logic [1:0] lane_low;
  assign lane_low = {~cur.ucas_n, ~cur.lcas_n};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_en[i]  <= 1'b0;
        wr_en[i]  <= 1'b0;
        drv_en[i] <= 1'b0;
      end else begin
        rd_en[i]  <= acc_next & lane_low[i % 2] & cur.we_n;
        wr_en[i]  <= acc_next & lane_low[i % 2] & ~cur.we_n;
        drv_en[i] <= acc_next & lane_low[i % 2] & cur.we_n & ~cur.oe_n & ~cur.ras_n;
      end
    end
  end

  assert_rd_wr_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en & wr_en) == '0);

  assert_drive_needs_oe_R10: assert property (@(posedge clk) disable iff (rst)
    (drv_en != '0) |-> $past(!cur.oe_n));

endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder
  import sdec_pkg::*;
#(
  parameter int WORD_AW    = 22,
  parameter int ROW_W      = 13,
  parameter int LOW_POWER  = 1,
  parameter int SREF_ENTRY = 64,
  parameter int SREF_TICK  = 512,
  localparam int COL_W     = WORD_AW - ROW_W,
  localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        cyc_type,
  output logic [ROW_W-1:0]  act_row,
  output logic [COL_W-1:0]  col_addr,
  output logic [1:0]        rd_en,
  output logic [1:0]        wr_en,
  output logic [1:0]        lane_oe
);

  strobes_s         pins, cur, prev;
  logic [ADDR_W-1:0] addr_q;
  logic [ROW_W-1:0]  cnt;
  logic              step, acc_next;
  cyc_e              cyc;

  assign pins = '{ras_n: ras_n, lcas_n: lcas_n, ucas_n: ucas_n, we_n: we_n, oe_n: oe_n};

  sdec_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk(clk), .rst(rst), .pins(pins), .addr_pins(addr),
    .cur(cur), .prev(prev), .addr_q(addr_q)
  );

  sdec_refresh_counter #(.W(ROW_W)) u_counter (
    .clk(clk), .rst(rst), .step(step), .cnt(cnt)
  );

  sdec_cycle_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .LOW_POWER(LOW_POWER),
    .SREF_ENTRY(SREF_ENTRY), .SREF_TICK(SREF_TICK)
  ) u_fsm (
    .clk(clk), .rst(rst), .cur(cur), .prev(prev), .addr_q(addr_q), .cnt(cnt),
    .step(step), .acc_next(acc_next), .cyc(cyc), .row(act_row), .col(col_addr)
  );

  sdec_lane_ctrl #(.LANES(2)) u_lanes (
    .clk(clk), .rst(rst), .cur(cur), .acc_next(acc_next),
    .rd_en(rd_en), .wr_en(wr_en), .drv_en(lane_oe)
  );

  assign cyc_type = cyc;

endmodule

// File: tb/strobe_cycle_decoder_bench.sv
module strobe_cycle_decoder_bench;

  localparam int ROW_W = 11;
  localparam int COL_W = 22 - ROW_W;
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int SREF_ENTRY = 8;
  localparam int SREF_TICK = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ras_n = 1, lcas_n = 1, ucas_n = 1, we_n = 1, oe_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [2:0] cyc_type;
  logic [ROW_W-1:0] act_row;
  logic [COL_W-1:0] col_addr;
  logic [1:0] rd_en, wr_en, lane_oe;

  int errors = 0, checks = 0;
  bit done = 0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  strobe_cycle_decoder #(
    .ROW_W(ROW_W), .LOW_POWER(1), .SREF_ENTRY(SREF_ENTRY), .SREF_TICK(SREF_TICK)
  ) u_strobe_cycle_decoder (
    .clk(clk), .rst(rst), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .cyc_type(cyc_type), .act_row(act_row),
    .col_addr(col_addr), .rd_en(rd_en), .wr_en(wr_en), .lane_oe(lane_oe)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 cyc", cyc_type, 0);
    chk("R1 row", act_row, 0);
    chk("R1 col", col_addr, 0);
    chk("R1 lanes", {rd_en, wr_en, lane_oe}, 0);

    // R2 row-only refresh over several rows, R11 return to none
    for (int r = 0; r < 16; r++) begin
      addr = ADDR_W'((r * 131 + 7) % (1 << ROW_W));
      ras_n = 0; step(2);
      chk("R2 cyc", cyc_type, 4);
      chk("R2 row", act_row, (r * 131 + 7) % (1 << ROW_W));
      ras_n = 1; step(2);
      chk("R11 cyc", cyc_type, 0);
    end

    // R3 R9 R10 lane sweep: lanes x write strobe x output enable
    for (int l = 1; l < 4; l++) begin
      for (int w = 0; w < 2; w++) begin
        for (int o = 0; o < 2; o++) begin
          int c;
          c = (l * 37 + w * 500 + o * 999) % (1 << COL_W);
          addr = ADDR_W'(l * 5); ras_n = 0; step(2);
          addr = ADDR_W'(c); we_n = w[0]; oe_n = o[0];
          lcas_n = ~l[0]; ucas_n = ~l[1]; step(2);
          chk("R3 cyc", cyc_type, w ? 1 : 2);
          chk("R3 col", col_addr, c);
          chk("R9 rd", rd_en, w ? l : 0);
          chk("R9 wr", wr_en, w ? 0 : l);
          chk("R10 oe", lane_oe, (w && !o) ? l : 0);
          lcas_n = 1; ucas_n = 1; step(2);
          ras_n = 1; we_n = 1; oe_n = 1; step(2);
          chk("R11 lanes", {rd_en, wr_en, lane_oe}, 0);
        end
      end
    end

    // R3 page mode: second column fall in one row cycle
    addr = 3; ras_n = 0; step(2);
    addr = 100; lcas_n = 0; ucas_n = 0; step(2);
    chk("R3 page first", col_addr, 100);
    lcas_n = 1; ucas_n = 1; step(2);
    addr = 201; we_n = 0; lcas_n = 0; ucas_n = 0; step(2);
    chk("R3 page col", col_addr, 201);
    chk("R3 page cyc", cyc_type, 2);
    lcas_n = 1; ucas_n = 1; we_n = 1; step(2);
    ras_n = 1; step(2);

    // R4 read-modify-write
    addr = 9; ras_n = 0; step(2);
    addr = 333; lcas_n = 0; ucas_n = 0; oe_n = 0; step(2);
    chk("R4 pre", cyc_type, 1);
    we_n = 0; oe_n = 1; step(2);
    chk("R4 cyc", cyc_type, 3);
    chk("R4 col", col_addr, 333);
    chk("R4 wr", wr_en, 3);
    chk("R4 rd", rd_en, 0);
    lcas_n = 1; ucas_n = 1; we_n = 1; step(2);
    ras_n = 1; step(2);

    // R5 column-before-row over the full counter range plus wrap
    lcas_n = 0; ucas_n = 0; we_n = 1; step(2);
    for (int i = 0; i <= (1 << ROW_W); i++) begin
      ras_n = 0; step(2);
      if (i == 0) chk("R5 cyc", cyc_type, 5);
      chk("R5 row", act_row, exp_cnt % (1 << ROW_W));
      exp_cnt++;
      ras_n = 1; step(2);
    end

    // R6 write-low refresh form is ignored
    we_n = 0; step(2);
    ras_n = 0; step(2);
    chk("R6 cyc", cyc_type, 0);
    chk("R6 lanes", {rd_en, wr_en, lane_oe}, 0);
    ras_n = 1; step(2);
    we_n = 1; step(2);
    ras_n = 0; step(2);
    chk("R6 counter", act_row, exp_cnt % (1 << ROW_W));
    exp_cnt++;
    ras_n = 1; step(2);
    lcas_n = 1; ucas_n = 1; step(2);

    // R7 hidden refresh after a read with column strobes held
    addr = 17; ras_n = 0; step(2);
    addr = 444; lcas_n = 0; ucas_n = 0; oe_n = 0; step(2);
    ras_n = 1; step(2);
    chk("R11 gap cyc", cyc_type, 0);
    chk("R11 gap oe", lane_oe, 0);
    ras_n = 0; step(2);
    chk("R7 cyc", cyc_type, 6);
    chk("R7 row", act_row, exp_cnt % (1 << ROW_W));
    chk("R7 col", col_addr, 444);
    chk("R7 oe", lane_oe, 3);
    exp_cnt++;
    lcas_n = 1; ucas_n = 1; oe_n = 1; step(2);
    ras_n = 1; step(2);

    // R8 self refresh
    lcas_n = 0; ucas_n = 0; step(2);
    ras_n = 0; step(2);
    chk("R8 cbr first", cyc_type, 5);
    step(12);
    chk("R8 cyc", cyc_type, 7);
    begin
      int a;
      a = act_row;
      step(SREF_TICK);
      chk("R8 tick1", act_row, (a + 1) % (1 << ROW_W));
      step(SREF_TICK);
      chk("R8 tick2", act_row, (a + 2) % (1 << ROW_W));
    end
    ras_n = 1; step(2);
    chk("R8 exit", cyc_type, 0);
    lcas_n = 1; ucas_n = 1; step(2);

    done = 1;
    summary();
  end

endmodule